// File: doc/BRIEF.md
# Programmable Skew Clock Phase Generator

This block produces eight clock outputs, grouped into four pairs, from a fast tick clock whose period is one skew time unit. A modulo-N phase counter defines one nominal output period of N ticks. Each pair can be shifted by a whole number of ticks ahead of or behind a zero-phase reference, divided by two or four, or inverted. The choice is made by two three-level selects per pair. A three-level range select picks N. The analog loop that would multiply a reference up to the tick rate is outside this block: it is the purely digital phase and divide generator that sits behind such a loop.

A test select bypasses the phase counter. In bypass, a reference input drives the outputs directly, while each pair keeps its own invert or divide function. Select changes made while the counter runs are held back until the next counter wrap, so an output never shows a shortened pulse.

Top module: `skew_phase_gen`

## Requirements
- R1: While `rst` is high at a rising edge, every output is low after that edge. The phase counter, the period (divider) counter and the sampled reference are cleared, and the range and pair selects are loaded.
- R2: Three-level codes are 2'b00 = LOW, 2'b01 = MID, 2'b10 = HIGH, and 2'b11 counts as MID. The range select gives N = 44 for LOW, 26 for MID and 16 for HIGH. A zero-offset output repeats every N ticks and is high for N/2 of them.
- R3: Pair p is selected by `sel_hi[2p+1:2p]` (first letter) and `sel_lo[2p+1:2p]` (second letter). For pairs 0 and 1, the offsets in ticks are LL −4, LM −3, LH −2, ML −1, MM 0, MH +1, HL +2, HM +3, HH +4.
- R4: For pairs 2 and 3, the offsets in ticks are LM −6, LH −4, ML −2, MM 0, MH +2, HL +4, HM +6.
- R5: For pair 2, LL selects divide-by-2 and HH selects divide-by-4. For pair 3, LL selects divide-by-2 and HH selects the zero-phase output inverted.
- R6: Periods are counted from reset modulo 4. A divide-by-2 output is high in odd periods. A divide-by-4 output is high in periods 0 and 1. Every divide-by-4 falling edge therefore coincides with a divide-by-2 falling edge.
- R7: Outputs are registered. After the j-th rising edge that follows reset, a running output reflects phase p = (j−1) mod N. An output with offset k is high when (p − k) mod N < N/2, and an inverted output is high when p ≥ N/2.
- R8: Changes to the range or pair selects during normal running take effect only at the edge where the phase counter wraps from N−1 to 0.
- R9: A `test_sel` of MID, HIGH or 2'b11 selects bypass. Offsets are then ignored, shifted pairs follow `ref_in` with two ticks of latency, an inverted pair follows its complement, and the period counter advances on each sampled rising edge of `ref_in`. Selects load on every tick in bypass.
- R10: Both outputs of a pair carry the same value on every tick.
- R11: When bypass ends, the phase counter restarts at phase 0, so a zero-offset pair is high after the first running edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, one skew time unit per period |
| rst | input | 1 | Synchronous active-high reset |
| range_sel | input | 2 | Three-level range code that sets N |
| test_sel | input | 2 | Three-level code; LOW runs the counter, other codes select bypass |
| ref_in | input | 1 | Reference level used in bypass |
| sel_hi | input | 8 | First-letter select per pair, two bits per pair |
| sel_lo | input | 8 | Second-letter select per pair, two bits per pair |
| q_a | output | 4 | First output of each pair |
| q_b | output | 4 | Second output of each pair |

## Verification
The hardest situation to reach is a select or range change that lands in the middle of a period. The output must keep its old phase until the wrap and then jump cleanly to the new phase and period length. The stimulus changes selects and range at random ticks and holds each setting for a random number of ticks, so changes fall at many phase positions. A cycle-by-cycle model predicts every output from the requirement tables. Directed phases then cover the ±6 extremes, the 2'b11 code, falling-edge alignment of the dividers, bypass with one-tick reference pulses, and the restart at phase 0 when bypass ends.

// File: rtl/skew_pkg.sv
package skew_pkg;

    localparam int NUM_PAIRS = 4;
    localparam int LANES     = 2;

    typedef enum logic [1:0] {
        FN_SHIFT = 2'd0,
        FN_DIV2  = 2'd1,
        FN_DIV4  = 2'd2,
        FN_INV   = 2'd3
    } pair_fn_e;

    typedef struct packed {
        pair_fn_e            fn;
        logic signed [3:0]   off;
    } pair_cfg_t;

    // three-level code: 00 low, 01 mid, 10 high, 11 folded onto mid
    function automatic logic [1:0] lvl_norm(input logic [1:0] code);
        return (code == 2'b11) ? 2'b01 : code;
    endfunction

    // R3 R4 R5: per-pair select decoding
    function automatic pair_cfg_t decode_pair(input int unsigned pidx,
                                              input logic [1:0] hi,
                                              input logic [1:0] lo);
        pair_cfg_t c;
        int t;
        t     = 3 * int'(lvl_norm(hi)) + int'(lvl_norm(lo));
        c.fn  = FN_SHIFT;
        c.off = 4'sd0;
        if (pidx < 2) begin
            c.off = 4'(t - 4);
        end else if (t == 0) begin
            c.fn = FN_DIV2;
        end else if (t == 8) begin
            c.fn = (pidx == 2) ? FN_DIV4 : FN_INV;
        end else begin
            c.off = 4'(2 * t - 8);
        end
        return c;
    endfunction

endpackage

// File: rtl/skew_timebase.sv
module skew_timebase #(
    parameter int N_LOW  = 44,
    parameter int N_MID  = 26,
    parameter int N_HIGH = 16,
    parameter int CW     = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bypass,
    input  logic          ref_in,
    input  logic [1:0]    range_sel,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] n_act,
    output logic [1:0]    per,
    output logic          ref_q,
    output logic          load
);
    import skew_pkg::*;

    logic wrap;
    logic ref_rise;

    function automatic logic [CW-1:0] pick_n(input logic [1:0] code);
        case (lvl_norm(code))
            2'b00:   return CW'(N_LOW);
            2'b10:   return CW'(N_HIGH);
            default: return CW'(N_MID);
        endcase
    endfunction

    assign wrap     = !bypass && (cnt == n_act - CW'(1));
    assign ref_rise = ref_in && !ref_q;
    assign load     = rst || bypass || wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            per   <= '0;
            ref_q <= 1'b0;
            n_act <= pick_n(range_sel);
        end else begin
            ref_q <= ref_in;
            if (load) begin
                cnt   <= '0;
                n_act <= pick_n(range_sel);
            end else begin
                cnt <= cnt + CW'(1);
            end
            if (bypass ? ref_rise : wrap)
                per <= per + 2'd1;
        end
    end

endmodule

// File: rtl/skew_pair_out.sv
module skew_pair_out #(
    parameter int PAIR_IDX = 0,
    parameter int CW       = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          bypass,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] n_act,
    input  logic [1:0]    per,
    input  logic          ref_q,
    input  logic [1:0]    code_hi,
    input  logic [1:0]    code_lo,
    output logic          q_a,
    output logic          q_b
);
    import skew_pkg::*;

    pair_cfg_t  cfg;
    logic       nxt;
    logic       shift_hi;
    logic       inv_hi;
    logic [LANES-1:0] q_r;

    always_ff @(posedge clk) begin
        if (load)
            cfg <= decode_pair(PAIR_IDX, code_hi, code_lo);
    end

    always_comb begin
        int d;
        int n;
        n = int'(n_act);
        d = int'(cnt) - int'($signed(cfg.off));
        if (d < 0)
            d = d + n;
        else if (d >= n)
            d = d - n;
        shift_hi = (d < n / 2);
        inv_hi   = (int'(cnt) >= n / 2);
        case (cfg.fn)
            FN_DIV2: nxt = per[0];
            FN_DIV4: nxt = !per[1];
            FN_INV:  nxt = bypass ? !ref_q : inv_hi;
            default: nxt = bypass ? ref_q : shift_hi;
        endcase
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)
                q_r[l] <= 1'b0;
            else
                q_r[l] <= nxt;
        end
    end

    assign q_a = q_r[0];
    assign q_b = q_r[1];

endmodule

// File: rtl/skew_phase_gen.sv
module skew_phase_gen #(
    parameter int N_LOW  = 44,
    parameter int N_MID  = 26,
    parameter int N_HIGH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] range_sel,
    input  logic [1:0] test_sel,
    input  logic       ref_in,
    input  logic [7:0] sel_hi,
    input  logic [7:0] sel_lo,
    output logic [3:0] q_a,
    output logic [3:0] q_b
);
    import skew_pkg::*;

    localparam int N_MAX = (N_LOW > N_MID) ? ((N_LOW > N_HIGH) ? N_LOW : N_HIGH)
                                           : ((N_MID > N_HIGH) ? N_MID : N_HIGH);
    localparam int CW = $clog2(N_MAX + 1);

    logic          bypass;
    logic [CW-1:0] cnt;
    logic [CW-1:0] n_act;
    logic [1:0]    per;
    logic          ref_q;
    logic          load;

    assign bypass = (test_sel != 2'b00);

    skew_timebase #(
        .N_LOW (N_LOW),
        .N_MID (N_MID),
        .N_HIGH(N_HIGH),
        .CW    (CW)
    ) u_tb (
        .clk      (clk),
        .rst      (rst),
        .bypass   (bypass),
        .ref_in   (ref_in),
        .range_sel(range_sel),
        .cnt      (cnt),
        .n_act    (n_act),
        .per      (per),
        .ref_q    (ref_q),
        .load     (load)
    );

    for (genvar gp = 0; gp < NUM_PAIRS; gp++) begin : g_pair
        skew_pair_out #(
            .PAIR_IDX(gp),
            .CW      (CW)
        ) u_pair (
            .clk    (clk),
            .rst    (rst),
            .load   (load),
            .bypass (bypass),
            .cnt    (cnt),
            .n_act  (n_act),
            .per    (per),
            .ref_q  (ref_q),
            .code_hi(sel_hi[2*gp +: 2]),
            .code_lo(sel_lo[2*gp +: 2]),
            .q_a    (q_a[gp]),
            .q_b    (q_b[gp])
        );
    end

endmodule

// File: rtl/skew_phase_gen_chk.sv
module skew_phase_gen_chk #(
    parameter int CW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          bypass,
    input logic          ref_in,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] n_act,
    input logic [1:0]    per,
    input logic [3:0]    q_a,
    input logic [3:0]    q_b
);

    // R1
    reset_low_chk: assert property (@(posedge clk)
        rst |=> (q_a == 4'd0 && q_b == 4'd0));

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < n_act);

    // R8
    range_at_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(n_act) |-> (cnt == '0));

    // R6
    period_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(per) && !$past(rst)) |->
            ($past(bypass) || ($past(cnt) == $past(n_act) - CW'(1))));

    // R9
    bypass_follow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(bypass) && !$past(rst) && !$past(rst, 2)) |->
            (q_a[0] == $past(ref_in, 2)));

    // R10
    pair_match_chk: assert property (@(posedge clk) disable iff (rst)
        q_a == q_b);

endmodule

bind skew_phase_gen skew_phase_gen_chk #(.CW(CW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .bypass(bypass),
    .ref_in(ref_in),
    .cnt   (cnt),
    .n_act (n_act),
    .per   (per),
    .q_a   (q_a),
    .q_b   (q_b)
);

// File: tb/test_skew_phase_gen.sv
module test_skew_phase_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] range_sel = 2'b10;
    logic [1:0] test_sel = 2'b00;
    logic       ref_in = 1'b0;
    logic [7:0] sel_hi = 8'h55;
    logic [7:0] sel_lo = 8'h55;
    logic [3:0] q_a;
    logic [3:0] q_b;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    skew_phase_gen i_skew_phase_gen (
        .clk      (clk),
        .rst      (rst),
        .range_sel(range_sel),
        .test_sel (test_sel),
        .ref_in   (ref_in),
        .sel_hi   (sel_hi),
        .sel_lo   (sel_lo),
        .q_a      (q_a),
        .q_b      (q_b)
    );

    // ---------------- expectation functions from the requirement tables
    function automatic int lvl(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b10) ? 2 : 1;   // R2: 11 -> MID
    endfunction

    function automatic int n_of(input logic [1:0] c);
        case (lvl(c))
            0: return 44;
            2: return 16;
            default: return 26;
        endcase
    endfunction

    // kind: 0 shift, 1 div2, 2 div4, 3 invert
    function automatic void kind_of(input int p, input logic [1:0] hi, input logic [1:0] lo,
                                    output int kind, output int off);
        int t;
        t = 3 * lvl(hi) + lvl(lo);
        kind = 0;
        off  = 0;
        if (p < 2) begin
            case (t)                       // R3
                0: off = -4; 1: off = -3; 2: off = -2;
                3: off = -1; 4: off = 0;  5: off = 1;
                6: off = 2;  7: off = 3;  default: off = 4;
            endcase
        end else begin
            case (t)                       // R4 R5
                0: kind = 1;
                1: off = -6; 2: off = -4; 3: off = -2; 4: off = 0;
                5: off = 2;  6: off = 4;  7: off = 6;
                default: kind = (p == 2) ? 2 : 3;
            endcase
        end
    endfunction

    function automatic logic exp_bit(input int p, input logic [1:0] hi, input logic [1:0] lo,
                                     input bit byp, input int cnt, input int n,
                                     input int per, input bit refq);
        int kind, off;
        kind_of(p, hi, lo, kind, off);
        if (kind == 1) return (per % 2) == 1;            // R6
        if (kind == 2) return (per % 4) < 2;             // R6
        if (kind == 3) return byp ? !refq : (cnt >= n / 2);
        if (byp) return refq;                            // R9
        return ((cnt - off + n) % n) < n / 2;            // R7
    endfunction

    function automatic string tag_of(input int p, input logic [1:0] hi, input logic [1:0] lo,
                                     input bit byp);
        int kind, off;
        kind_of(p, hi, lo, kind, off);
        if (byp) return "R9";
        if (kind != 0) return "R5";
        return (p < 2) ? "R3" : "R4";
    endfunction

    // ---------------- cycle model, driven only by the bench's own inputs
    bit         m_valid = 1'b0;
    int         m_cnt, m_n, m_per;
    bit         m_refq;
    logic [1:0] m_hi [4];
    logic [1:0] m_lo [4];
    logic       m_out [4];
    string      m_tag [4];
    bit         m_byp, m_wr, m_rs;

    always @(posedge clk) begin
        if (rst) begin
            m_valid = 1'b1;
            m_cnt = 0; m_per = 0; m_refq = 1'b0;
            m_n = n_of(range_sel);
            for (int p = 0; p < 4; p++) begin
                m_out[p] = 1'b0;
                m_hi[p]  = sel_hi[2*p +: 2];
                m_lo[p]  = sel_lo[2*p +: 2];
                m_tag[p] = "R1";
            end
        end else begin
            m_byp = (test_sel != 2'b00);
            for (int p = 0; p < 4; p++) begin
                m_out[p] = exp_bit(p, m_hi[p], m_lo[p], m_byp, m_cnt, m_n, m_per, m_refq);
                m_tag[p] = tag_of(p, m_hi[p], m_lo[p], m_byp);
            end
            m_rs = ref_in && !m_refq;
            m_wr = !m_byp && (m_cnt == m_n - 1);
            if (m_byp ? m_rs : m_wr) m_per = m_per + 1;
            if (m_byp || m_wr) begin            // R8: load only at wrap
                m_cnt = 0;
                m_n = n_of(range_sel);
                for (int p = 0; p < 4; p++) begin
                    m_hi[p] = sel_hi[2*p +: 2];
                    m_lo[p] = sel_lo[2*p +: 2];
                end
            end else begin
                m_cnt = m_cnt + 1;
            end
            m_refq = ref_in;
        end
    end

    always @(negedge clk) begin
        if (m_valid && !done) begin
            for (int p = 0; p < 4; p++) begin
                n_cmp++;
                if (q_a[p] !== m_out[p]) begin
                    n_bad++;
                    $display("FAIL R7/R8 %s pair %0d: q_a=%b expected %b", m_tag[p], p, q_a[p], m_out[p]);
                end
                n_cmp++;
                if (q_b[p] !== q_a[p]) begin   // R10
                    n_bad++;
                    $display("FAIL R10 pair %0d: q_b=%b expected %b", p, q_b[p], q_a[p]);
                end
            end
        end
    end

    // ---------------- directed helpers
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_rise0();
        logic l;
        l = q_a[0];
        forever begin
            @(negedge clk);
            if (q_a[0] && !l) break;
            l = q_a[0];
        end
    endtask

    task automatic measure_period(input int expn);
        int len, hi;
        logic l;
        wait_rise0();
        wait_rise0();
        l = 1'b1; hi = 1; len = 0;
        forever begin
            @(negedge clk);
            len++;
            if (q_a[0] && !l) break;
            if (q_a[0]) hi++;
            l = q_a[0];
        end
        check(len == expn, "R2 period", len, expn);
        check(hi == expn / 2, "R2 high time", hi, expn / 2);
    endtask

    task automatic toggle_ref(input int times);
        for (int i = 0; i < times; i++) begin
            @(negedge clk);
            ref_in = ~ref_in;
            repeat ($urandom_range(0, 5)) @(negedge clk);
        end
    endtask

    initial begin
        #1ms;
        n_bad++;
        $display("FAIL R7 watchdog: actual running expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic l2, l3;
        int falls;
        seed = $urandom(32'd2024);

        // R1: outputs held low during reset
        repeat (4) @(negedge clk);
        check(q_a == 4'd0 && q_b == 4'd0, "R1 reset", int'({q_a, q_b}), 0);
        rst = 1'b0;

        // R2: period and duty per range
        measure_period(16);
        range_sel = 2'b00;
        measure_period(44);
        range_sel = 2'b01;
        measure_period(26);
        range_sel = 2'b11;                     // 11 treated as MID
        measure_period(26);

        // R3 R4 R5 R8: random selects, changed at random phases
        range_sel = 2'b10;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            sel_hi = 8'($urandom);
            sel_lo = 8'($urandom);
            if ($urandom_range(0, 3) == 0) range_sel = 2'($urandom);
            repeat ($urandom_range(20, 150)) @(negedge clk);
        end

        // R3 R4: extreme offsets
        @(negedge clk);
        range_sel = 2'b10;
        sel_hi = 8'h88;
        sel_lo = 8'h58;
        repeat (100) @(negedge clk);
        sel_hi = 8'hFF; sel_lo = 8'hFF;        // all codes 11 -> MM
        repeat (60) @(negedge clk);

        // R6: divide-by-4 on pair 2, divide-by-2 on pair 3, falls aligned
        sel_hi = 8'h25; sel_lo = 8'h25;
        repeat (40) @(negedge clk);
        falls = 0;
        l2 = q_a[2]; l3 = q_a[3];
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            if (l2 && !q_a[2]) begin
                falls++;
                check(l3 && !q_a[3], "R6 aligned fall", int'(q_a[3]), 0);
            end
            l2 = q_a[2]; l3 = q_a[3];
        end
        check(falls >= 4, "R6 fall count", falls, 4);

        // R9: bypass with every non-LOW test code
        sel_hi = 8'($urandom); sel_lo = 8'($urandom);
        test_sel = 2'b01;
        toggle_ref(60);
        sel_hi = 8'hA5; sel_lo = 8'hA5;        // pair2 div4, pair3 invert
        test_sel = 2'b10;
        toggle_ref(60);
        sel_hi = 8'h25; sel_lo = 8'h25;        // pair2 div4, pair3 div2
        test_sel = 2'b11;
        toggle_ref(60);

        // R11: leaving bypass restarts at phase 0
        @(negedge clk);
        test_sel = 2'b00;
        @(negedge clk);
        check(q_a[0] == 1'b1, "R11 restart phase 0", int'(q_a[0]), 1);
        repeat (120) @(negedge clk);

        // R1: reset in mid-run
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check(q_a == 4'd0 && q_b == 4'd0, "R1 mid-run reset", int'({q_a, q_b}), 0);
        rst = 1'b0;
        repeat (80) @(negedge clk);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule